// File: doc/BRIEF.md
# Debugger Console Packet Framer

This block sits between a console character producer and a UART. It gathers outgoing characters into a line buffer. When a line is complete, it emits the line as a console-output packet for a remote debugger. The packet is a dollar sign and an 'O' marker, then the payload written as uppercase ASCII hex with two digits per byte, then a hash sign and a two-digit hex checksum.

After the last checksum digit, the block waits for one byte from the UART receiver. That byte decides what happens next:
- A plus sign releases the buffer.
- A Ctrl-C byte releases the buffer and fires a one-cycle break request toward the debug logic.
- Any other byte makes the block repeat the same packet from its first byte.

The input side is a valid/ready byte stream, and its ready is withheld for the whole life of a packet. The output side is a valid/ready byte stream toward the UART transmitter.

Top module: `dbg_console_framer`

## Requirements
- R1: An input byte 0x0D (carriage return) is accepted and dropped; it never shows up in any payload.
- R2: Accepting the byte 0x0A (line feed) completes the line and starts a packet. The 0x0A is the last payload byte. in_ready is low in the cycle after it is accepted.
- R3: A line with no line feed completes when its LINE_MAX-th stored byte (default 100) is accepted. The packet carries exactly LINE_MAX payload bytes, and no further input is accepted until the packet is released.
- R4: Packet byte order on tx_data is fixed:
  - 0x24 ('$')
  - 0x4F ('O')
  - for each payload byte in arrival order, its upper-nibble digit and then its lower-nibble digit
  - 0x23 ('#')
  - the checksum upper-nibble digit, then the checksum lower-nibble digit
- R5: Hex digits map nibble values 0-9 to 0x30-0x39 and values 10-15 to 0x41-0x46.
- R6: The checksum is the modulo-256 sum of every byte sent between the '$' and the '#', 'O' included.
- R7: In the acknowledge wait, an rx byte 0x2B ('+') ends the packet and empties the buffer. in_ready returns high two cycles after that rx byte is taken.
- R8: In the acknowledge wait, an rx byte 0x03 raises brk_req for exactly one cycle (the cycle after the byte is taken) and ends the packet as R7 does. brk_req is never high otherwise.
- R9: In the acknowledge wait, any other rx byte makes the whole packet, from '$' onward, be sent again unchanged. The input stays blocked meanwhile.
- R10: in_ready is low whenever tx_valid is high.
- R11: Once tx_valid is high with tx_ready low, tx_valid and tx_data hold their values into the next cycle.
- R12: After reset, in_ready is high, tx_valid is low and brk_req is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 8 | Console character from the producer |
| in_valid | input | 1 | in_data is offered |
| in_ready | output | 1 | Framer can take a character |
| tx_data | output | 8 | Packet byte toward the UART transmitter |
| tx_valid | output | 1 | tx_data is offered |
| tx_ready | input | 1 | Transmitter takes tx_data |
| rx_data | input | 8 | Byte from the UART receiver |
| rx_valid | input | 1 | rx_data is present for this cycle |
| brk_req | output | 1 | One-cycle break request after a Ctrl-C acknowledge |

## Verification
The assertions assume that rx_valid pulses last one cycle per received byte. The break-cause property ties brk_req to the rx byte of the previous cycle. The stability and blocking properties hold for any tx_ready pattern.

The stimulus drives tx_ready with a periodic stall, so that held bytes are exercised. It sends each acknowledge byte only after the last checksum digit has been taken, as a single-cycle rx_valid pulse. Input bytes are offered only under valid/ready handshakes, so a blocked input never loses data.

// File: rtl/dbgf_pkg.sv
package dbgf_pkg;

  localparam logic [7:0] CH_START = 8'h24;
  localparam logic [7:0] CH_END   = 8'h23;
  localparam logic [7:0] CH_OUT   = 8'h4F;
  localparam logic [7:0] CH_ACK   = 8'h2B;
  localparam logic [7:0] CH_BRK   = 8'h03;
  localparam logic [7:0] CH_CR    = 8'h0D;
  localparam logic [7:0] CH_LF    = 8'h0A;

  typedef enum logic [3:0] {
    E_IDLE,
    E_START,
    E_MARK,
    E_FETCH,
    E_HI,
    E_LO,
    E_END,
    E_CKHI,
    E_CKLO,
    E_WAIT
  } emit_st_t;

  function automatic logic [7:0] hex_ascii(input logic [3:0] v);
    if (v < 4'd10) return 8'h30 + {4'd0, v};
    else           return 8'h37 + {4'd0, v};
  endfunction

endpackage

// File: rtl/dbgf_line_ram.sv
module dbgf_line_ram #(
  parameter int DEPTH = 100,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/dbgf_collector.sv
module dbgf_collector #(
  parameter int LINE_MAX = 100,
  parameter int AW       = $clog2(LINE_MAX),
  parameter int CW       = $clog2(LINE_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [7:0]    in_data,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          release_buf,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          start,
  output logic [CW-1:0] line_len
);
  import dbgf_pkg::*;

  logic [CW-1:0] cnt;
  logic          hold;
  logic          take;
  logic          store;
  logic          closes;

  assign in_ready = ~hold;
  assign take     = in_valid & ~hold;
  assign store    = take & (in_data != CH_CR);
  assign closes   = (in_data == CH_LF) | (cnt == CW'(LINE_MAX - 1));

  assign wr_en   = store;
  assign wr_addr = AW'(cnt);
  assign wr_data = in_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      hold     <= 1'b0;
      start    <= 1'b0;
      line_len <= '0;
    end else begin
      start <= 1'b0;
      if (release_buf) begin
        hold <= 1'b0;
        cnt  <= '0;
      end else if (store) begin
        if (closes) begin
          hold     <= 1'b1;
          start    <= 1'b1;
          line_len <= cnt + CW'(1);
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  // R3
  fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(LINE_MAX));

  // R2
  close_block_chk: assert property (@(posedge clk) disable iff (rst)
    (store && in_data == CH_LF) |=> !in_ready);

endmodule

// File: rtl/dbgf_emitter.sv
module dbgf_emitter #(
  parameter int LINE_MAX = 100,
  parameter int AW       = $clog2(LINE_MAX),
  parameter int CW       = $clog2(LINE_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] line_len,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data,
  output logic [7:0]    tx_data,
  output logic          tx_valid,
  input  logic          tx_ready,
  input  logic [7:0]    rx_data,
  input  logic          rx_valid,
  output logic          brk_req,
  output logic          done
);
  import dbgf_pkg::*;

  emit_st_t      st, nxt_st;
  logic [7:0]    cur_byte;
  logic [7:0]    sum;
  logic [CW-1:0] idx;
  logic          sending;
  logic          fire;
  logic          last;

  assign fire    = tx_valid & tx_ready;
  assign last    = (idx == line_len - CW'(1));
  assign rd_en   = (st == E_FETCH);
  assign rd_addr = AW'(idx);
  assign sending = (st == E_START) | (st == E_MARK) | (st == E_HI) |
                   (st == E_LO) | (st == E_END) | (st == E_CKHI) |
                   (st == E_CKLO);

  always_comb begin
    case (st)
      E_START: cur_byte = CH_START;
      E_MARK:  cur_byte = CH_OUT;
      E_HI:    cur_byte = hex_ascii(rd_data[7:4]);
      E_LO:    cur_byte = hex_ascii(rd_data[3:0]);
      E_END:   cur_byte = CH_END;
      E_CKHI:  cur_byte = hex_ascii(sum[7:4]);
      E_CKLO:  cur_byte = hex_ascii(sum[3:0]);
      default: cur_byte = 8'h00;
    endcase
  end

  always_comb begin
    case (st)
      E_START: nxt_st = E_MARK;
      E_MARK:  nxt_st = E_FETCH;
      E_HI:    nxt_st = E_LO;
      E_LO:    nxt_st = last ? E_END : E_FETCH;
      E_END:   nxt_st = E_CKHI;
      E_CKHI:  nxt_st = E_CKLO;
      E_CKLO:  nxt_st = E_WAIT;
      default: nxt_st = st;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= E_IDLE;
      tx_valid <= 1'b0;
      tx_data  <= 8'h00;
      sum      <= 8'h00;
      idx      <= '0;
      brk_req  <= 1'b0;
      done     <= 1'b0;
    end else begin
      brk_req <= 1'b0;
      done    <= 1'b0;
      if (sending) begin
        if (!tx_valid) begin
          tx_valid <= 1'b1;
          tx_data  <= cur_byte;
        end else if (tx_ready) begin
          tx_valid <= 1'b0;
          st       <= nxt_st;
          if (st == E_START) begin
            sum <= 8'h00;
            idx <= '0;
          end
          if (st == E_MARK || st == E_HI || st == E_LO)
            sum <= sum + tx_data;
          if (st == E_LO && !last)
            idx <= idx + CW'(1);
        end
      end else begin
        case (st)
          E_IDLE:  if (start) st <= E_START;
          E_FETCH: st <= E_HI;
          E_WAIT: begin
            if (rx_valid) begin
              if (rx_data == CH_ACK) begin
                done <= 1'b1;
                st   <= E_IDLE;
              end else if (rx_data == CH_BRK) begin
                brk_req <= 1'b1;
                done    <= 1'b1;
                st      <= E_IDLE;
              end else begin
                st <= E_START;
              end
            end
          end
          default: st <= E_IDLE;
        endcase
      end
    end
  end

  // R11
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R8
  brk_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    brk_req |=> !brk_req);

  // R8
  brk_cause_chk: assert property (@(posedge clk) disable iff (rst)
    brk_req |-> $past(rx_valid && rx_data == CH_BRK));

  // R9
  resend_chk: assert property (@(posedge clk) disable iff (rst)
    (st == E_WAIT && rx_valid && rx_data != CH_ACK && rx_data != CH_BRK)
      |=> (st == E_START && !done));

endmodule

// File: rtl/dbg_console_framer.sv
module dbg_console_framer #(
  parameter int LINE_MAX = 100
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  output logic       in_ready,
  output logic [7:0] tx_data,
  output logic       tx_valid,
  input  logic       tx_ready,
  input  logic [7:0] rx_data,
  input  logic       rx_valid,
  output logic       brk_req
);
  import dbgf_pkg::*;

  localparam int AW = (LINE_MAX > 1) ? $clog2(LINE_MAX) : 1;
  localparam int CW = $clog2(LINE_MAX + 1);

  logic          wr_en, rd_en, start, done;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [7:0]    wr_data, rd_data;
  logic [CW-1:0] line_len;

  dbgf_collector #(.LINE_MAX(LINE_MAX), .AW(AW), .CW(CW)) u_coll (
    .clk(clk), .rst(rst),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .release_buf(done),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .start(start), .line_len(line_len)
  );

  dbgf_line_ram #(.DEPTH(LINE_MAX), .AW(AW)) u_ram (
    .clk(clk),
    .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .re(rd_en), .raddr(rd_addr), .rdata(rd_data)
  );

  dbgf_emitter #(.LINE_MAX(LINE_MAX), .AW(AW), .CW(CW)) u_emit (
    .clk(clk), .rst(rst),
    .start(start), .line_len(line_len),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid),
    .brk_req(brk_req), .done(done)
  );

  // R10
  tx_blocks_in_chk: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> !in_ready);

  // R1
  cr_never_stored_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_data != CH_CR));

endmodule

// File: tb/dbg_console_framer_bench.sv
module dbg_console_framer_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] in_data = 8'h00;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] tx_data;
  logic       tx_valid;
  logic       tx_ready = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       rx_valid = 1'b0;
  logic       brk_req;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic [7:0] expq[$];
  logic [7:0] last_pl[$];
  logic       held = 1'b0;
  logic [7:0] held_data = 8'h00;

  always #4 clk = ~clk;

  dbg_console_framer u_dbg_console_framer (
    .clk(clk), .rst(rst),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .brk_req(brk_req)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] hx(input int v);
    if (v < 10) return 8'(48 + v);
    return 8'(65 + v - 10);
  endfunction

  // R4 R5 R6: build the expected packet
  task automatic expect_packet(input logic [7:0] p[$]);
    int s;
    s = 8'h4F;
    expq.push_back(8'h24);
    expq.push_back(8'h4F);
    foreach (p[i]) begin
      expq.push_back(hx(p[i] / 16));
      expq.push_back(hx(p[i] % 16));
      s += hx(p[i] / 16) + hx(p[i] % 16);
    end
    s = s % 256;
    expq.push_back(8'h23);
    expq.push_back(hx(s / 16));
    expq.push_back(hx(s % 16));
  endtask

  task automatic push_byte(input logic [7:0] b);
    @(negedge clk);
    in_data  = b;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_line(input logic [7:0] s[$]);
    last_pl.delete();
    foreach (s[i]) if (s[i] != 8'h0D) last_pl.push_back(s[i]);
    expect_packet(last_pl);
    foreach (s[i]) push_byte(s[i]);
    // R2 R3: input blocked right after the closing byte
    chk(in_ready == 1'b0, "R2/R3 blocked after close", int'(in_ready), 0);
  endtask

  task automatic reply(input logic [7:0] b);
    logic fin;
    fin = (b == 8'h2B) || (b == 8'h03);
    wait (expq.size() == 0);
    @(negedge clk);
    if (!fin) expect_packet(last_pl);
    rx_data  = b;
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
    chk(brk_req == (b == 8'h03), "R8 break pulse", int'(brk_req), int'(b == 8'h03));
    @(negedge clk);
    chk(brk_req == 1'b0, "R8 break one cycle", int'(brk_req), 0);
    if (fin) chk(in_ready == 1'b1, "R7 released", int'(in_ready), 1);
    else     chk(in_ready == 1'b0, "R9 still blocked", int'(in_ready), 0);
  endtask

  // scoreboard monitor: checks R4 R5 R6 R9 R10 R11
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (held) begin
        chk(tx_valid && tx_data == held_data, "R11 hold", int'(tx_data), int'(held_data));
      end
      tx_ready = (cyc % 4) != 1;
      held = tx_valid && !tx_ready;
      held_data = tx_data;
      if (tx_valid) begin
        chk(in_ready == 1'b0, "R10 input blocked", int'(in_ready), 0);
      end
      if (tx_valid && tx_ready) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R4 unexpected byte", int'(tx_data), 0);
        end else begin
          logic [7:0] e;
          e = expq.pop_front();
          chk(tx_data == e, "R4/R5/R6 packet byte", int'(tx_data), int'(e));
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", expq.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] l[$];
    repeat (3) @(negedge clk);
    // R12
    chk(in_ready == 1'b1, "R12 in_ready", int'(in_ready), 1);
    chk(tx_valid == 1'b0, "R12 tx_valid", int'(tx_valid), 0);
    chk(brk_req == 1'b0, "R12 brk_req", int'(brk_req), 0);
    rst = 1'b0;

    // R2 R4 R6 R7: simple line
    l = '{8'h48, 8'h69, 8'h0A};
    send_line(l);
    reply(8'h2B);

    // R1: carriage returns dropped
    l = '{8'h61, 8'h0D, 8'h0D, 8'h7A, 8'h0A};
    send_line(l);
    reply(8'h2B);

    // R5: digit range extremes
    l = '{8'h00, 8'hFF, 8'h9A, 8'h0F, 8'hA9, 8'h0A};
    send_line(l);
    reply(8'h2B);

    // R9: nak then resend, then another bad byte, then ack
    l = '{8'h51, 8'h0A};
    send_line(l);
    reply(8'h2D);
    reply(8'h00);
    reply(8'h2B);

    // R8: Ctrl-C acknowledge
    l = '{8'h43, 8'h0A};
    send_line(l);
    reply(8'h03);

    // R3: full buffer without line feed
    l.delete();
    for (int i = 0; i < 100; i++) l.push_back(8'(8'h20 + i));
    send_line(l);
    reply(8'h2B);

    // R7: buffer emptied, next short line is correct
    l = '{8'h0A};
    send_line(l);
    reply(8'h2B);

    wait (expq.size() == 0);
    repeat (4) @(negedge clk);
    chk(tx_valid == 1'b0, "R7 idle after ack", int'(tx_valid), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule